// File: doc/BRIEF.md
# Transmit DMA Run/Stop Controller

This block is the control core of a descriptor-driven transmit DMA engine. It has three states: stopped, running and suspended. It decides when a descriptor should be fetched. It holds the address of the current descriptor. It raises a sticky flag when software has not handed over the next buffer. Data movement, the bus master and the transmit FIFO sit outside the block. The block sees only three things from that side: the ownership (available) bit of each fetched descriptor, an optional chained offset, and a pulse that marks the end of each frame.

Software starts the engine by raising the enable input. Dropping the enable input is a soft request. A frame already on the wire is allowed to finish, and only then does the engine stop. The descriptor pointer is kept across stops, so a later start resumes at the descriptor where the engine stopped. The programmed base address is used only on the first start after reset or after the base register has been written again. While the engine is suspended, a poll-demand pulse makes it retry the same descriptor.

Top module: `txdma_runctl`

## Requirements
- R1: After reset the state is stopped, `fetch_req` is 0, `cur_ptr` is 0 and `unavail_flag` is 0.
- R2: In the stopped state, a sampled `run_en`=1 moves the engine to running at the next edge. In the fetch phase of running, `fetch_req` is 1.
- R3: A start from stopped loads `cur_ptr` from `base_addr` only if no start has happened since reset or since the last `base_wr` pulse. Any other start keeps `cur_ptr` unchanged.
- R4: In the fetch phase, a `fetch_done` with `desc_avail`=0 moves the engine to suspended and sets `unavail_flag` at the same edge. `cur_ptr` does not change.
- R5: If `run_en` is 0 while a frame is being sent, the state stays running until `frame_done`. At that edge the engine goes to stopped.
- R6: At each accepted `frame_done`, `cur_ptr` advances. The step is 16 (the `STRIDE` parameter) if `chain_mode` was 0 at the accepting `fetch_done`, and `desc_next` sampled at that same edge if `chain_mode` was 1.
- R7: In the suspended state, `run_en`=0 moves the engine to stopped at the next edge.
- R8: In the suspended state with `run_en`=1, a `poll_demand` pulse returns the engine to the fetch phase of running with `cur_ptr` unchanged.
- R9: `unavail_flag` stays set until an `unavail_clr` pulse clears it. A set and a clear at the same edge leave the flag set.
- R10: `run_en`=0 during the fetch phase stops the engine at the next edge, and a `fetch_done` in that same cycle is ignored. `fetch_done` is ignored outside the fetch phase, and `frame_done` is ignored outside the send phase.
- R11: The `state` encoding is 2'b00 stopped, 2'b01 running and 2'b10 suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Software start/stop enable level |
| base_addr | input | AW | Programmed first-descriptor address |
| base_wr | input | 1 | Pulse: base register was rewritten |
| chain_mode | input | 1 | Use the chained offset instead of the fixed stride |
| poll_demand | input | 1 | Pulse: retry the descriptor while suspended |
| unavail_clr | input | 1 | Write-1-to-clear pulse for the unavailable flag |
| fetch_done | input | 1 | Pulse: the descriptor fetch has returned |
| desc_avail | input | 1 | Ownership bit of the fetched descriptor |
| desc_next | input | AW | Chained offset to the next descriptor |
| frame_done | input | 1 | Pulse: the current frame has finished sending |
| fetch_req | output | 1 | Request to fetch the descriptor at cur_ptr |
| cur_ptr | output | AW | Current descriptor address |
| unavail_flag | output | 1 | Sticky transmit-buffer-unavailable status |
| state | output | 2 | Engine state (see R11) |

## Verification
A wrong run/send phase shows up on `fetch_req` in the very next cycle: either the request is missing or an extra one appears. A wrongly stored step or a lost base-pending bit stays hidden until the next `frame_done` or the next restart. At that point `cur_ptr` holds the wrong address, and it stays wrong for every later descriptor. The bench therefore compares all four outputs against a behavioural model on every clock. It also drives stop/restart and re-poll sequences long enough to expose a wrong pointer held over from an earlier step.

// File: rtl/txdma_runctl_pkg.sv
package txdma_runctl_pkg;
   typedef enum logic [1:0] {
      TX_STOP = 2'b00,
      TX_RUN  = 2'b01,
      TX_SUSP = 2'b10
   } txst_e;
endpackage

// File: rtl/txdma_fsm.sv
module txdma_fsm
   import txdma_runctl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run_en,
   input  logic  poll_demand,
   input  logic  fetch_done,
   input  logic  desc_avail,
   input  logic  frame_done,
   output txst_e st,
   output logic  sending,
   output logic  start,
   output logic  lat,
   output logic  miss,
   output logic  adv
);
   txst_e st_d;
   logic  snd_d;
   logic  fetching;

   assign fetching = (st == TX_RUN) && !sending;
   assign start    = (st == TX_STOP) && run_en;
   assign lat      = fetching && run_en && fetch_done && desc_avail;
   assign miss     = fetching && run_en && fetch_done && !desc_avail;
   assign adv      = (st == TX_RUN) && sending && frame_done;

   always_comb begin
      st_d  = st;
      snd_d = sending;
      case (st)
         TX_STOP: begin
            if (run_en) begin
               st_d  = TX_RUN;
               snd_d = 1'b0;
            end
         end
         TX_RUN: begin
            if (!sending) begin
               if (!run_en)   st_d  = TX_STOP;
               else if (lat)  snd_d = 1'b1;
               else if (miss) st_d  = TX_SUSP;
            end else if (frame_done) begin
               snd_d = 1'b0;
               if (!run_en) st_d = TX_STOP;
            end
         end
         TX_SUSP: begin
            if (!run_en) st_d = TX_STOP;
            else if (poll_demand) begin
               st_d  = TX_RUN;
               snd_d = 1'b0;
            end
         end
         default: begin
            st_d  = TX_STOP;
            snd_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= TX_STOP;
         sending <= 1'b0;
      end else begin
         st      <= st_d;
         sending <= snd_d;
      end
   end

   // R5
   hold_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_RUN && sending && !frame_done) |=> (st == TX_RUN));

   // R7
   susp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_SUSP && !run_en) |=> (st == TX_STOP));

   // R4
   susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_SUSP && $past(st) != TX_SUSP) |-> ($past(st) == TX_RUN));

   // R11
   enc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != 2'b11));
endmodule

// File: rtl/txdma_ptr.sv
module txdma_ptr #(
   parameter int AW       = 32,
   parameter int STRIDE   = 16,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          lat,
   input  logic          adv,
   input  logic          base_wr,
   input  logic [AW-1:0] base_addr,
   input  logic          chain_mode,
   input  logic [AW-1:0] desc_next,
   output logic [AW-1:0] cur_ptr
);
   localparam logic [AW-1:0] STEP_FIX = AW'(STRIDE);

   logic          pend_q;
   logic [AW-1:0] step_q;

   generate
      if (CHAIN_EN) begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n)   step_q <= STEP_FIX;
            else if (lat) step_q <= chain_mode ? desc_next : STEP_FIX;
         end
      end else begin : g_linear
         assign step_q = STEP_FIX;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b1;
         cur_ptr <= '0;
      end else begin
         if (start && (pend_q || base_wr)) cur_ptr <= base_addr;
         else if (adv)                     cur_ptr <= cur_ptr + step_q;
         if (start)        pend_q <= 1'b0;
         else if (base_wr) pend_q <= 1'b1;
      end
   end

   // R8
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !adv) |=> $stable(cur_ptr));
endmodule

// File: rtl/txdma_flag.sv
module txdma_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/txdma_runctl.sv
module txdma_runctl
   import txdma_runctl_pkg::*;
#(
   parameter int AW       = 32,
   parameter int STRIDE   = 16,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [AW-1:0] base_addr,
   input  logic          base_wr,
   input  logic          chain_mode,
   input  logic          poll_demand,
   input  logic          unavail_clr,
   input  logic          fetch_done,
   input  logic          desc_avail,
   input  logic [AW-1:0] desc_next,
   input  logic          frame_done,
   output logic          fetch_req,
   output logic [AW-1:0] cur_ptr,
   output logic          unavail_flag,
   output logic [1:0]    state
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("txdma_runctl: AW must be at least 8");
      end
      if (STRIDE <= 0 || (STRIDE & (STRIDE - 1)) != 0) begin : g_bad_stride
         $error("txdma_runctl: STRIDE must be a positive power of two");
      end
   endgenerate

   txst_e st;
   logic  sending, start, lat, miss, adv;

   txdma_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_demand(poll_demand),
      .fetch_done(fetch_done), .desc_avail(desc_avail), .frame_done(frame_done),
      .st(st), .sending(sending), .start(start), .lat(lat), .miss(miss), .adv(adv)
   );

   txdma_ptr #(.AW(AW), .STRIDE(STRIDE), .CHAIN_EN(CHAIN_EN)) u_ptr (
      .clk(clk), .rst_n(rst_n), .start(start), .lat(lat), .adv(adv),
      .base_wr(base_wr), .base_addr(base_addr), .chain_mode(chain_mode),
      .desc_next(desc_next), .cur_ptr(cur_ptr)
   );

   txdma_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(miss), .clr(unavail_clr), .flag(unavail_flag)
   );

   assign fetch_req = (st == TX_RUN) && !sending;
   assign state     = st;

   // R4
   miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && run_en && fetch_done && !desc_avail) |=> (unavail_flag && state == 2'b10));

   // R10
   fetch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !run_en) |=> (state == 2'b00 && $stable(cur_ptr)));
endmodule

// File: tb/sim_txdma_runctl.sv
`timescale 1ns/1ps
module sim_txdma_runctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0, base_wr = 1'b0, chain_mode = 1'b0, poll_demand = 1'b0;
   logic        unavail_clr = 1'b0, fetch_done = 1'b0, desc_avail = 1'b0, frame_done = 1'b0;
   logic [31:0] base_addr = '0, desc_next = '0;
   logic        fetch_req, unavail_flag;
   logic [31:0] cur_ptr;
   logic [1:0]  state;

   int checks = 0, fails = 0, cyc = 0;

   always #2 clk = ~clk;

   txdma_runctl u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .base_addr(base_addr), .base_wr(base_wr),
      .chain_mode(chain_mode), .poll_demand(poll_demand), .unavail_clr(unavail_clr),
      .fetch_done(fetch_done), .desc_avail(desc_avail), .desc_next(desc_next),
      .frame_done(frame_done), .fetch_req(fetch_req), .cur_ptr(cur_ptr),
      .unavail_flag(unavail_flag), .state(state)
   );

   // behavioural reference model
   int          m_st = 0;
   bit          m_send = 0, m_pend = 1, m_flag = 0;
   logic [31:0] m_ptr = 0, m_step = 16;

   always @(posedge clk) begin
      int n_st; bit n_send, n_pend, n_flag, go; logic [31:0] n_ptr, n_step;
      if (!rst_n) begin
         m_st = 0; m_send = 0; m_pend = 1; m_flag = 0; m_ptr = 0; m_step = 16;
      end else begin
         n_st = m_st; n_send = m_send; n_pend = m_pend; n_flag = m_flag;
         n_ptr = m_ptr; n_step = m_step;
         go = (m_st == 0) && run_en;
         if (unavail_clr) n_flag = 0;
         if (m_st == 0) begin
            if (run_en) begin
               n_st = 1; n_send = 0;
               if (m_pend || base_wr) n_ptr = base_addr;
               n_pend = 0;
            end
         end else if (m_st == 1) begin
            if (!m_send) begin
               if (!run_en) n_st = 0;
               else if (fetch_done) begin
                  if (desc_avail) begin n_send = 1; n_step = chain_mode ? desc_next : 32'd16; end
                  else begin n_st = 2; n_flag = 1; end
               end
            end else if (frame_done) begin
               n_ptr = m_ptr + m_step; n_send = 0;
               if (!run_en) n_st = 0;
            end
         end else begin
            if (!run_en) n_st = 0;
            else if (poll_demand) begin n_st = 1; n_send = 0; end
         end
         if (!go && base_wr) n_pend = 1;
         m_st = n_st; m_send = n_send; m_pend = n_pend; m_flag = n_flag;
         m_ptr = n_ptr; m_step = n_step;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks += 4;
         if (state !== 2'(m_st)) begin fails++; $display("FAIL R2 state act=%0d exp=%0d", state, m_st); end
         if (cur_ptr !== m_ptr) begin fails++; $display("FAIL R6 cur_ptr act=%h exp=%h", cur_ptr, m_ptr); end
         if (unavail_flag !== m_flag) begin fails++; $display("FAIL R9 flag act=%0b exp=%0b", unavail_flag, m_flag); end
         if (fetch_req !== (m_st == 1 && !m_send)) begin
            fails++; $display("FAIL R2 fetch_req act=%0b exp=%0b", fetch_req, (m_st == 1 && !m_send));
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
   endtask

   task automatic fetch(input bit av, input bit ch, input logic [31:0] nx);
      int guard = 0;
      while (!fetch_req && guard < 50) begin step(); guard++; end
      fetch_done = 1; desc_avail = av; chain_mode = ch; desc_next = nx;
      step();
      fetch_done = 0; desc_avail = 0; chain_mode = 0; desc_next = 0;
   endtask

   task automatic frame();
      frame_done = 1; step(); frame_done = 0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      chk("R1 state", 32'(state), 32'h0);
      chk("R1 ptr", cur_ptr, 32'h0);
      chk("R1 flag", 32'(unavail_flag), 32'h0);
      chk("R1 fetch_req", 32'(fetch_req), 32'h0);

      base_addr = 32'h1000; base_wr = 1; step(); base_wr = 0;
      run_en = 1; step();
      chk("R2 state running", 32'(state), 32'h1);
      chk("R11 running code", 32'(state), 32'h1);
      chk("R2 fetch_req", 32'(fetch_req), 32'h1);
      chk("R3 base loaded", cur_ptr, 32'h1000);
      fetch(1, 0, 0);
      chk("R2 send phase no req", 32'(fetch_req), 32'h0);
      frame();
      chk("R6 linear step", cur_ptr, 32'h1010);
      fetch(1, 1, 32'h40);
      frame();
      chk("R6 chain step", cur_ptr, 32'h1050);

      fetch(0, 0, 0);
      chk("R4 suspended", 32'(state), 32'h2);
      chk("R11 suspend code", 32'(state), 32'h2);
      chk("R4 flag set", 32'(unavail_flag), 32'h1);
      chk("R4 ptr held", cur_ptr, 32'h1050);
      repeat (3) step();
      chk("R9 flag sticky", 32'(unavail_flag), 32'h1);
      unavail_clr = 1; step(); unavail_clr = 0;
      chk("R9 flag cleared", 32'(unavail_flag), 32'h0);
      poll_demand = 1; step(); poll_demand = 0;
      chk("R8 poll refetch", 32'(fetch_req), 32'h1);
      chk("R8 same ptr", cur_ptr, 32'h1050);
      unavail_clr = 1; fetch(0, 0, 0); unavail_clr = 0;
      chk("R9 set wins", 32'(unavail_flag), 32'h1);

      run_en = 0; step();
      chk("R7 susp to stop", 32'(state), 32'h0);
      chk("R11 stop code", 32'(state), 32'h0);
      fetch_done = 1; desc_avail = 1; step(); fetch_done = 0; desc_avail = 0;
      chk("R10 fetch_done ignored", 32'(state), 32'h0);
      frame(); 
      chk("R10 frame_done ignored", cur_ptr, 32'h1050);
      base_addr = 32'h2000;
      run_en = 1; step();
      chk("R3 resume ptr", cur_ptr, 32'h1050);
      fetch(1, 0, 0);
      run_en = 0; repeat (4) step();
      chk("R5 still running", 32'(state), 32'h1);
      frame();
      chk("R5 stop after frame", 32'(state), 32'h0);
      chk("R5 ptr advanced", cur_ptr, 32'h1060);

      run_en = 1; step();
      fetch_done = 1; desc_avail = 1; run_en = 0; step(); fetch_done = 0; desc_avail = 0;
      chk("R10 abort fetch", 32'(state), 32'h0);
      chk("R10 ptr kept", cur_ptr, 32'h1060);

      base_addr = 32'h3000; base_wr = 1; step(); base_wr = 0;
      base_addr = 32'h0;
      run_en = 1; step();
      chk("R3 base rewrite loaded", cur_ptr, 32'h0);
      fetch(1, 0, 0); frame();
      chk("R6 step from new base", cur_ptr, 32'h10);
      run_en = 0; repeat (3) step();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++; checks++;
         $display("FAIL watchdog act=%0d exp=finish", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule